// File: doc/BRIEF.md
# FP32 Compare and Flag Unit

This block compares two IEEE-754 single-precision values and reduces the outcome to one of four relations: greater, less, equal or unordered. The relation is written as a three-bit condition pattern into a zero, parity and carry flag register. Three auxiliary flags (overflow, sign, adjust) are written as zero. Only the low 32 bits of each operand bus take part. The rest of the bus is ignored.

Each compare also raises two exception indications in the same cycle as its strobe: invalid-operation and denormal. A mode input picks a quiet or a signalling policy for NaN operands, and this decides which NaN kinds raise invalid. Each exception has a mask input. A raised exception whose mask is clear blocks the flag register write, so software still sees the flags from the last successful compare.

Top module: `fp32_cmp_flags`

## Requirements
- R1: One clock edge after a strobe that loads, {zf_o,pf_o,cf_o} shows the relation of lhs to rhs: greater = 3'b000, less = 3'b001, equal = 3'b100, unordered = 3'b111.
- R2: The relation is unordered whenever either operand is a NaN. A NaN has exponent bits [30:23] all ones and a nonzero fraction [22:0]. Bit 22 set means quiet, bit 22 clear means signalling.
- R3: With cmp_sig_i = 0 (quiet policy), inv_o is high only when at least one operand is a signalling NaN.
- R4: With cmp_sig_i = 1 (signalling policy), inv_o is high when either operand is a NaN of any kind.
- R5: of_o, sf_o and af_o are 0 after reset and after every compare.
- R6: When a raised exception has its mask input at 0, the flag register keeps its previous value. A raised exception whose mask is 1 does not stop the load.
- R7: den_o is high during a strobe when either operand is subnormal, that is exponent zero and fraction nonzero.
- R8: Operand bits above bit 31 have no effect on the relation or the exceptions.
- R9: +0 and -0 compare equal. Infinities order by sign like finite values.
- R10: Non-NaN values order by sign first and then by magnitude. When both are negative, the larger magnitude is the lesser value.
- R11: Reset clears all six flags. inv_o and den_o are 0 in any cycle without a strobe, and the flags do not change in such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmp_vld_i | input | 1 | Compare strobe |
| cmp_sig_i | input | 1 | 0 selects the quiet NaN policy, 1 selects the signalling NaN policy |
| lhs_i | input | OP_W | First operand bus; bits [31:0] are used |
| rhs_i | input | OP_W | Second operand bus; bits [31:0] are used |
| msk_inv_i | input | 1 | 1 masks the invalid exception |
| msk_den_i | input | 1 | 1 masks the denormal exception |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag, always written 0 |
| sf_o | output | 1 | Sign flag, always written 0 |
| af_o | output | 1 | Adjust flag, always written 0 |
| inv_o | output | 1 | Invalid-operation indication, valid with the strobe |
| den_o | output | 1 | Denormal indication, valid with the strobe |

## Verification
The hardest case to reach from the ports is a blocked write. The flag register has to already hold a known non-reset value, and the next strobe has to raise an exception with its mask cleared. If either part is missing, a broken hold path looks just like a correct one. The directed sequence first loads "equal" with a clean compare. It then sends a signalling NaN with the invalid mask clear, and after that a subnormal with the denormal mask clear, and checks that the flags stay at the equal pattern. Last, the same NaN is sent with the mask set, and the flags must move to unordered. The vector table fills the upper operand bits with junk so that bits outside the low word are exercised in every compare.

// File: rtl/fp32_cmp_pkg.sv
package fp32_cmp_pkg;

  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int FLG_W  = 6;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
    logic             is_sub;
  } fp_cls_t;

  // {zf,pf,cf} pattern for a relation
  function automatic logic [2:0] rel_to_zpc(rel_e r);
    case (r)
      REL_GT:  return 3'b000;
      REL_LT:  return 3'b001;
      REL_EQ:  return 3'b100;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/fp32_classify.sv
module fp32_classify
  import fp32_cmp_pkg::*;
(
  input  logic [FP_W-1:0] word_i,
  output fp_cls_t         cls_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_none;
  logic              frac_any;

  always_comb begin
    exp_f    = word_i[FP_W-2 -: EXP_W];
    frac_f   = word_i[FRAC_W-1:0];
    exp_ones = &exp_f;
    exp_none = ~|exp_f;
    frac_any = |frac_f;

    cls_o.sign    = word_i[FP_W-1];
    cls_o.mag     = word_i[MAG_W-1:0];
    cls_o.is_nan  = exp_ones & frac_any;
    cls_o.is_snan = exp_ones & frac_any & ~frac_f[FRAC_W-1];
    cls_o.is_zero = exp_none & ~frac_any;
    cls_o.is_sub  = exp_none & frac_any;
  end

endmodule

// File: rtl/fp32_order.sv
module fp32_order
  import fp32_cmp_pkg::*;
(
  input  fp_cls_t a_i,
  input  fp_cls_t b_i,
  output rel_e    rel_o
);

  logic mag_gt;
  logic mag_eq;

  always_comb begin
    mag_gt = a_i.mag > b_i.mag;
    mag_eq = a_i.mag == b_i.mag;

    if (a_i.is_nan || b_i.is_nan) begin
      rel_o = REL_UN;
    end else if (a_i.is_zero && b_i.is_zero) begin
      rel_o = REL_EQ;
    end else if (a_i.sign != b_i.sign) begin
      rel_o = a_i.sign ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel_o = REL_EQ;
    end else if (a_i.sign) begin
      rel_o = mag_gt ? REL_LT : REL_GT;
    end else begin
      rel_o = mag_gt ? REL_GT : REL_LT;
    end
  end

endmodule

// File: rtl/fp32_flag_reg.sv
module fp32_flag_reg
  import fp32_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [FLG_W-1:0] d_i,
  output logic [FLG_W-1:0] q_o
);

  logic [FLG_W-1:0] q_r;
  logic [FLG_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

endmodule

// File: rtl/fp32_cmp_flags.sv
module fp32_cmp_flags
  import fp32_cmp_pkg::*;
#(
  parameter int OP_W        = 128,
  parameter int RST_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_vld_i,
  input  logic            cmp_sig_i,
  input  logic [OP_W-1:0] lhs_i,
  input  logic [OP_W-1:0] rhs_i,
  input  logic            msk_inv_i,
  input  logic            msk_den_i,
  output logic            zf_o,
  output logic            pf_o,
  output logic            cf_o,
  output logic            of_o,
  output logic            sf_o,
  output logic            af_o,
  output logic            inv_o,
  output logic            den_o
);

  localparam int N_OPS = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[RST_STAGES-1];

  // classify the low word of each operand
  logic [FP_W-1:0] op_word [N_OPS];
  fp_cls_t         op_cls  [N_OPS];

  assign op_word[0] = lhs_i[FP_W-1:0];
  assign op_word[1] = rhs_i[FP_W-1:0];

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fp32_classify u_cls (
      .word_i (op_word[g]),
      .cls_o  (op_cls[g])
    );
  end

  rel_e rel;

  fp32_order u_ord (
    .a_i   (op_cls[0]),
    .b_i   (op_cls[1]),
    .rel_o (rel)
  );

  // exception policy
  logic any_nan, any_snan, any_sub;
  logic inv_raw, den_raw, blocked, load;
  logic [FLG_W-1:0] flg_d, flg_q;

  always_comb begin
    any_nan  = op_cls[0].is_nan  | op_cls[1].is_nan;
    any_snan = op_cls[0].is_snan | op_cls[1].is_snan;
    any_sub  = op_cls[0].is_sub  | op_cls[1].is_sub;
    inv_raw  = cmp_sig_i ? any_nan : any_snan;
    den_raw  = any_sub;
    blocked  = (inv_raw & ~msk_inv_i) | (den_raw & ~msk_den_i);
    load     = cmp_vld_i & ~blocked;
    // {zf,pf,cf,of,sf,af}
    flg_d    = {rel_to_zpc(rel), 3'b000};
  end

  fp32_flag_reg u_flg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (load),
    .d_i    (flg_d),
    .q_o    (flg_q)
  );

  assign {zf_o, pf_o, cf_o, of_o, sf_o, af_o} = flg_q;
  assign inv_o = cmp_vld_i & inv_raw;
  assign den_o = cmp_vld_i & den_raw;

  // ---------------- assertions ----------------
  assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_vld_i && any_nan && !blocked) |=> (zf_o && pf_o && cf_o));

  assert_quiet_inv_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_vld_i && !cmp_sig_i && inv_o) |-> (op_cls[0].is_snan || op_cls[1].is_snan));

  assert_sig_inv_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_vld_i && cmp_sig_i && (op_cls[0].is_nan || op_cls[1].is_nan)) |-> inv_o);

  assert_aux_zero_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(of_o || sf_o || af_o));

  assert_hold_blocked_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_vld_i && ((inv_o && !msk_inv_i) || (den_o && !msk_den_i)))
      |=> $stable({zf_o, pf_o, cf_o}));

  assert_zero_equal_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_cls[0].is_zero && op_cls[1].is_zero) |-> (rel == REL_EQ));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cmp_vld_i |-> (!inv_o && !den_o));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cmp_vld_i |=> $stable({zf_o, pf_o, cf_o}));

endmodule

// File: tb/fp32_cmp_flags_test.sv
module fp32_cmp_flags_test;

  localparam int OP_W = 128;
  localparam int NV   = 14;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmp_vld_i, cmp_sig_i, msk_inv_i, msk_den_i;
  logic [OP_W-1:0] lhs_i, rhs_i;
  logic            zf_o, pf_o, cf_o, of_o, sf_o, af_o, inv_o, den_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fp32_cmp_flags #(.OP_W(OP_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_vld_i(cmp_vld_i), .cmp_sig_i(cmp_sig_i),
    .lhs_i(lhs_i), .rhs_i(rhs_i), .msk_inv_i(msk_inv_i), .msk_den_i(msk_den_i),
    .zf_o(zf_o), .pf_o(pf_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .af_o(af_o),
    .inv_o(inv_o), .den_o(den_o)
  );

  // {lhs[31:0], rhs[31:0], sig, zpc[2:0], inv, den}
  localparam logic [69:0] VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 1'b0, 3'b001, 1'b0, 1'b0}, // R1 1<2
    {32'h40000000, 32'h3F800000, 1'b0, 3'b000, 1'b0, 1'b0}, // R1 2>1
    {32'h3F800000, 32'h3F800000, 1'b0, 3'b100, 1'b0, 1'b0}, // R1 eq
    {32'h00000000, 32'h80000000, 1'b0, 3'b100, 1'b0, 1'b0}, // R9 +0 -0
    {32'h7F800000, 32'hFF800000, 1'b0, 3'b000, 1'b0, 1'b0}, // R9 inf
    {32'hBF800000, 32'hC0000000, 1'b0, 3'b000, 1'b0, 1'b0}, // R10 -1>-2
    {32'hC0000000, 32'hBF800000, 1'b0, 3'b001, 1'b0, 1'b0}, // R10 -2<-1
    {32'h7FC00000, 32'h3F800000, 1'b0, 3'b111, 1'b0, 1'b0}, // R2 R3 qnan quiet
    {32'h7F800001, 32'h3F800000, 1'b0, 3'b111, 1'b1, 1'b0}, // R3 snan quiet
    {32'h3F800000, 32'h7FC00000, 1'b1, 3'b111, 1'b1, 1'b0}, // R4 qnan sig
    {32'h00000001, 32'h00000000, 1'b0, 3'b000, 1'b0, 1'b1}, // R7 sub > 0
    {32'hBF800000, 32'h3F800000, 1'b0, 3'b001, 1'b0, 1'b0}, // R1 -1<1
    {32'hFFC00000, 32'h7FC00000, 1'b1, 3'b111, 1'b1, 1'b0}, // R4 two qnan
    {32'h80000001, 32'h80000002, 1'b0, 3'b000, 1'b0, 1'b1}  // R10 R7 neg sub
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one strobe at a falling edge; sample exceptions mid-cycle,
  // flags at the following falling edge (one register stage)
  task automatic strobe(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                        input logic sig, input logic mi, input logic md,
                        output logic [1:0] exc, output logic [2:0] zpc);
    @(negedge clk);
    lhs_i = a; rhs_i = b; cmp_sig_i = sig; msk_inv_i = mi; msk_den_i = md;
    cmp_vld_i = 1'b1;
    #1 exc = {inv_o, den_o};
    @(negedge clk);
    cmp_vld_i = 1'b0;
    #1 zpc = {zf_o, pf_o, cf_o};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [1:0] exc;
    logic [2:0] zpc;
    rst_n = 1'b0; cmp_vld_i = 1'b0; cmp_sig_i = 1'b0;
    msk_inv_i = 1'b1; msk_den_i = 1'b1; lhs_i = '0; rhs_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset flags", {2'b0, zf_o, pf_o, cf_o, of_o, sf_o, af_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table, junk in upper operand bits (R8)
    for (int i = 0; i < NV; i++) begin
      logic [95:0] junk;
      junk = {3{32'h9E3779B9 * (i + 1)}};
      strobe({junk, VEC[i][69:38]}, {~junk, VEC[i][37:6]}, VEC[i][5],
             1'b1, 1'b1, exc, zpc);
      chk($sformatf("R1/R8 vec%0d relation", i), {5'b0, zpc}, {5'b0, VEC[i][4:2]});
      chk($sformatf("R3/R4/R7 vec%0d exceptions", i), {6'b0, exc}, {6'b0, VEC[i][1:0]});
      chk($sformatf("R5 vec%0d aux", i), {5'b0, of_o, sf_o, af_o}, 8'h00);
    end

    // R8: upper bits alone would invert the order
    strobe({{96{1'b1}}, 32'h3F800000}, {96'h0, 32'h40000000}, 1'b0, 1'b1, 1'b1, exc, zpc);
    chk("R8 upper bits ignored", {5'b0, zpc}, 8'h01);

    // R6: load equal, then blocked exceptions must hold it
    strobe({96'h0, 32'h3F800000}, {96'h0, 32'h3F800000}, 1'b0, 1'b1, 1'b1, exc, zpc);
    chk("R6 preload equal", {5'b0, zpc}, 8'h04);
    strobe({96'h0, 32'h7F800001}, {96'h0, 32'h3F800000}, 1'b0, 1'b0, 1'b1, exc, zpc);
    chk("R6 unmasked invalid raised", {6'b0, exc}, 8'h02);
    chk("R6 unmasked invalid holds", {5'b0, zpc}, 8'h04);
    strobe({96'h0, 32'h00000001}, {96'h0, 32'h3F800000}, 1'b0, 1'b1, 1'b0, exc, zpc);
    chk("R6 unmasked denormal holds", {5'b0, zpc}, 8'h04);
    strobe({96'h0, 32'h7F800001}, {96'h0, 32'h3F800000}, 1'b0, 1'b1, 1'b1, exc, zpc);
    chk("R6 masked invalid loads", {5'b0, zpc}, 8'h07);

    // R11: no strobe, NaN on the bus
    @(negedge clk);
    lhs_i = {96'h0, 32'h7F800001}; rhs_i = {96'h0, 32'h00000001}; cmp_sig_i = 1'b1;
    #1 chk("R11 idle exceptions", {6'b0, inv_o, den_o}, 8'h00);
    @(negedge clk);
    #1 chk("R11 idle flags hold", {5'b0, zf_o, pf_o, cf_o}, 8'h07);

    // R3: qNaN in quiet mode raises nothing but still unordered
    strobe({96'h0, 32'h3F800000}, {96'h0, 32'hFFC00001}, 1'b0, 1'b0, 1'b0, exc, zpc);
    chk("R3 qnan quiet no invalid", {6'b0, exc}, 8'h00);
    chk("R2 qnan unordered", {5'b0, zpc}, 8'h07);

    // R11: reset mid-run clears flags
    strobe({96'h0, 32'h3F800000}, {96'h0, 32'h3F800000}, 1'b0, 1'b1, 1'b1, exc, zpc);
    rst_n = 1'b0;
    #1 chk("R11 async reset", {2'b0, zf_o, pf_o, cf_o, of_o, sf_o, af_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule